// File: doc/BRIEF.md
# Remote Diode Fault Substitution

This block sits between the temperature conversion front end of a fan-controller monitor and its reading registers. It handles one or more remote diode channels. For each channel it takes a raw temperature code, a flag that says a fault was detected on the diode pins, a code that names the kind of fault, and a channel enable. It then decides which value is written into the reading register: the measured value, a sentinel, or zero. It also decides whether the sticky fault status bit for that channel is set.

The sentinel is the code with only the top bit set (80h for 8-bit readings). It is also treated as an over-temperature error. Whenever a channel's reading register holds the sentinel, the channel's diode error flag sets. The fan outputs that the channel's zone mask selects are also held at full speed for as long as the sentinel stays in the register. The fault status bit never reaches the error flag by itself. Only the substituted reading does that, so the interrupt logic downstream sees diode errors and not raw fault detections.

Each channel runs a small state machine. Its states are `RD_IDLE` (no conversion since reset), `RD_VALID` (holds a measured value), `RD_SENTINEL` (holds the sentinel) and `RD_ZEROED` (a disabled channel saw a fault). The only transition is a conversion-done strobe, taken from any state. The strobe goes to `RD_SENTINEL` when the loaded value equals the sentinel. It goes to `RD_ZEROED` when the zero substitution applies, and to `RD_VALID` otherwise. The full-speed request for a channel is active only in `RD_SENTINEL`.

Top module: `rdf_subst`

## Requirements
- R1: On a conversion strobe, an enabled channel with a detected fault of kind open (code 0), short-high (code 1) or pair-short (code 2) loads the sentinel 80h into its reading.
- R2: On a conversion strobe, an enabled channel with a fault of kind negative-to-ground (code 3) loads the raw value unchanged and still sets its fault status bit.
- R3: On a conversion strobe, a disabled channel with a detected fault of any kind loads 00h and does not set its fault status bit.
- R4: On a conversion strobe with no fault detected, the channel loads the raw value, whether it is enabled or not.
- R5: Readings change only on a clock edge where the conversion strobe is high. Between strobes they hold.
- R6: Every load of 80h into a reading sets that channel's diode error flag, including a measured 80h.
- R7: A fault status bit sets on a strobe with an enabled channel and a detected fault. A set fault bit never sets the diode error flag by itself: a negative-to-ground fault leaves the error flag clear.
- R8: Fan output z is requested at full speed exactly while some channel holds 80h in its reading and has bit z of its 3-bit zone mask set. The request drops on the strobe that replaces the 80h.
- R9: Fault status and diode error bits are sticky. A high clear input for a channel clears that bit at the next edge. When a set event and a clear happen on the same edge, the set wins.
- R10: After reset all readings are 00h, all status and error bits are 0, and no fan output is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| conv_done | input | 1 | Conversion-done strobe, one cycle per conversion |
| raw_temp | input | NCH*TW | Raw reading per channel, channel 0 in the low bits |
| fault_det | input | NCH | Fault detected on the channel's diode pins |
| fault_kind | input | NCH*2 | Fault kind: 0 open, 1 short-high, 2 pair-short, 3 negative-to-ground |
| chan_en | input | NCH | Channel enable |
| zone_mask | input | NCH*NZONE | Per-channel mask of fan outputs to force to full speed |
| fault_clr | input | NCH | Write-one-to-clear of the fault status bits |
| err_clr | input | NCH | Write-one-to-clear of the diode error bits |
| temp_reading | output | NCH*TW | Reading register per channel |
| fault_sts | output | NCH | Sticky fault status per channel |
| diode_err | output | NCH | Sticky diode error flag per channel, for the interrupt logic |
| fan_full | output | NZONE | Full-speed request per fan output |

## Verification
The properties assume that conv_done, fault_det, fault_kind, chan_en and raw_temp are settled at the edge where the strobe is sampled. They also assume that the clear inputs are plain one-cycle pulses. The zone property further assumes that zone_mask is steady while it is being compared. The bench changes every input on the falling clock edge. It keeps each strobe to a single cycle and moves the masks only between conversions, so every sampled edge meets these conditions.

// File: rtl/rdf_pkg.sv
package rdf_pkg;

    typedef enum logic [1:0] {
        RD_IDLE,
        RD_VALID,
        RD_SENTINEL,
        RD_ZEROED
    } rd_state_e;

    typedef enum logic [1:0] {
        FK_OPEN       = 2'd0,
        FK_SHORT_HI   = 2'd1,
        FK_SHORT_PAIR = 2'd2,
        FK_NEG_GND    = 2'd3
    } fault_kind_e;

    typedef enum logic [1:0] {
        LD_RAW,
        LD_SENTINEL,
        LD_ZERO
    } load_sel_e;

endpackage

// File: rtl/rdf_chan.sv
module rdf_chan
    import rdf_pkg::*;
#(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          conv_done,
    input  logic [TW-1:0] raw_i,
    input  logic          fault_i,
    input  logic [1:0]    kind_i,
    input  logic          en_i,
    output logic [TW-1:0] reading_o,
    output logic          sentinel_o,
    output logic          fault_evt_o,
    output logic          err_evt_o
);

    localparam logic [TW-1:0] SENT = {1'b1, {(TW-1){1'b0}}};

    rd_state_e     state_q, state_d;
    load_sel_e     sel;
    logic [TW-1:0] load_val;

    // substitution decision: negative-to-ground keeps the measured value
    always_comb begin
        if (fault_i && en_i && (fault_kind_e'(kind_i) != FK_NEG_GND))
            sel = LD_SENTINEL;
        else if (fault_i && !en_i)
            sel = LD_ZERO;
        else
            sel = LD_RAW;
    end

    always_comb begin
        unique case (sel)
            LD_SENTINEL: load_val = SENT;
            LD_ZERO:     load_val = '0;
            default:     load_val = raw_i;
        endcase
    end

    // next-state: every transition is taken on the conversion strobe
    always_comb begin
        state_d = state_q;
        if (conv_done) begin
            if (load_val == SENT)
                state_d = RD_SENTINEL;
            else if (sel == LD_ZERO)
                state_d = RD_ZEROED;
            else
                state_d = RD_VALID;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= RD_IDLE;
        else
            state_q <= state_d;
    end

    // reading register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            reading_o <= '0;
        else if (conv_done)
            reading_o <= load_val;
    end

    // state-decoded outputs
    always_comb begin
        unique case (state_q)
            RD_SENTINEL: sentinel_o = 1'b1;
            RD_IDLE,
            RD_VALID,
            RD_ZEROED:   sentinel_o = 1'b0;
            default:     sentinel_o = 1'b0;
        endcase
    end

    assign fault_evt_o = conv_done && fault_i && en_i;
    assign err_evt_o   = conv_done && (load_val == SENT);

endmodule

// File: rtl/rdf_sticky.sv
module rdf_sticky #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] q_o
);

    // set dominates a simultaneous clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q_o <= '0;
        else
            q_o <= (q_o & ~clr_i) | set_i;
    end

endmodule

// File: rtl/rdf_zone_map.sv
module rdf_zone_map #(
    parameter int NCH   = 2,
    parameter int NZONE = 3
) (
    input  logic [NCH-1:0]       active_i,
    input  logic [NCH*NZONE-1:0] mask_i,
    output logic [NZONE-1:0]     full_o
);

    for (genvar z = 0; z < NZONE; z++) begin : g_zone
        logic [NCH-1:0] hit;
        for (genvar c = 0; c < NCH; c++) begin : g_ch
            assign hit[c] = active_i[c] & mask_i[c*NZONE + z];
        end
        assign full_o[z] = |hit;
    end

endmodule

// File: rtl/rdf_subst.sv
module rdf_subst
    import rdf_pkg::*;
#(
    parameter int NCH   = 2,
    parameter int NZONE = 3,
    parameter int TW    = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 conv_done,
    input  logic [NCH*TW-1:0]    raw_temp,
    input  logic [NCH-1:0]       fault_det,
    input  logic [NCH*2-1:0]     fault_kind,
    input  logic [NCH-1:0]       chan_en,
    input  logic [NCH*NZONE-1:0] zone_mask,
    input  logic [NCH-1:0]       fault_clr,
    input  logic [NCH-1:0]       err_clr,
    output logic [NCH*TW-1:0]    temp_reading,
    output logic [NCH-1:0]       fault_sts,
    output logic [NCH-1:0]       diode_err,
    output logic [NZONE-1:0]     fan_full
);

    logic [NCH-1:0] sent_act;
    logic [NCH-1:0] fault_evt;
    logic [NCH-1:0] err_evt;

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        rdf_chan #(.TW(TW)) u_chan (
            .clk         (clk),
            .rst_n       (rst_n),
            .conv_done   (conv_done),
            .raw_i       (raw_temp[c*TW +: TW]),
            .fault_i     (fault_det[c]),
            .kind_i      (fault_kind[c*2 +: 2]),
            .en_i        (chan_en[c]),
            .reading_o   (temp_reading[c*TW +: TW]),
            .sentinel_o  (sent_act[c]),
            .fault_evt_o (fault_evt[c]),
            .err_evt_o   (err_evt[c])
        );
    end

    rdf_sticky #(.N(NCH)) u_fault_sts (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (fault_evt),
        .clr_i (fault_clr),
        .q_o   (fault_sts)
    );

    rdf_sticky #(.N(NCH)) u_diode_err (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (err_evt),
        .clr_i (err_clr),
        .q_o   (diode_err)
    );

    rdf_zone_map #(.NCH(NCH), .NZONE(NZONE)) u_zone (
        .active_i (sent_act),
        .mask_i   (zone_mask),
        .full_o   (fan_full)
    );

endmodule

// File: rtl/rdf_subst_chk.sv
module rdf_subst_chk #(
    parameter int NCH   = 2,
    parameter int NZONE = 3,
    parameter int TW    = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 conv_done,
    input logic [NCH*TW-1:0]    raw_temp,
    input logic [NCH-1:0]       fault_det,
    input logic [NCH*2-1:0]     fault_kind,
    input logic [NCH-1:0]       chan_en,
    input logic [NCH*NZONE-1:0] zone_mask,
    input logic [NCH-1:0]       fault_clr,
    input logic [NCH-1:0]       err_clr,
    input logic [NCH*TW-1:0]    temp_reading,
    input logic [NCH-1:0]       fault_sts,
    input logic [NCH-1:0]       diode_err,
    input logic [NZONE-1:0]     fan_full
);

    localparam logic [TW-1:0] SENT = {1'b1, {(TW-1){1'b0}}};

    logic [NCH-1:0] holds_sent;

    // R5
    hold_between_strobes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !conv_done |=> $stable(temp_reading));

    for (genvar c = 0; c < NCH; c++) begin : g_c
        assign holds_sent[c] = (temp_reading[c*TW +: TW] == SENT);

        // R1
        sentinel_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
            conv_done && chan_en[c] && fault_det[c] && (fault_kind[c*2 +: 2] != 2'd3)
            |=> temp_reading[c*TW +: TW] == SENT);

        // R3
        disabled_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            conv_done && !chan_en[c] && fault_det[c]
            |=> temp_reading[c*TW +: TW] == '0);

        // R3
        disabled_no_fault_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
            conv_done && !chan_en[c] && fault_det[c] && !fault_sts[c]
            |=> !fault_sts[c]);

        // R4
        raw_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
            conv_done && !fault_det[c]
            |=> temp_reading[c*TW +: TW] == $past(raw_temp[c*TW +: TW]));

        // R6
        err_on_sentinel_chk: assert property (@(posedge clk) disable iff (!rst_n)
            conv_done && ((chan_en[c] && fault_det[c] && (fault_kind[c*2 +: 2] != 2'd3))
                          || (!fault_det[c] && raw_temp[c*TW +: TW] == SENT))
            |=> diode_err[c]);

        // R9
        fault_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
            fault_sts[c] && !fault_clr[c] |=> fault_sts[c]);

        // R9
        err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
            diode_err[c] && !err_clr[c] |=> diode_err[c]);
    end

    for (genvar z = 0; z < NZONE; z++) begin : g_z
        logic [NCH-1:0] want;
        for (genvar c = 0; c < NCH; c++) begin : g_w
            assign want[c] = holds_sent[c] & zone_mask[c*NZONE + z];
        end
        // R8
        zone_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
            fan_full[z] == (|want));
    end

endmodule

bind rdf_subst rdf_subst_chk #(.NCH(NCH), .NZONE(NZONE), .TW(TW)) u_rdf_chk (.*);

// File: tb/test_rdf_subst.sv
`timescale 1ns/1ps
module test_rdf_subst;

    localparam int NCH = 2;
    localparam int NZONE = 3;
    localparam int TW = 8;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 conv_done = 1'b0;
    logic [NCH*TW-1:0]    raw_temp = '0;
    logic [NCH-1:0]       fault_det = '0;
    logic [NCH*2-1:0]     fault_kind = '0;
    logic [NCH-1:0]       chan_en = '0;
    logic [NCH*NZONE-1:0] zone_mask = '0;
    logic [NCH-1:0]       fault_clr = '0;
    logic [NCH-1:0]       err_clr = '0;
    logic [NCH*TW-1:0]    temp_reading;
    logic [NCH-1:0]       fault_sts;
    logic [NCH-1:0]       diode_err;
    logic [NZONE-1:0]     fan_full;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    rdf_subst #(.NCH(NCH), .NZONE(NZONE), .TW(TW)) i_rdf_subst (.*);

    // {en, fault, kind[1:0], raw[7:0], exp_reading[7:0], exp_fault_bit}
    localparam int NV = 10;
    localparam logic [20:0] VEC [NV] = '{
        {1'b1, 1'b0, 2'd0, 8'h45, 8'h45, 1'b0},  // R4 enabled, no fault
        {1'b1, 1'b1, 2'd0, 8'h45, 8'h80, 1'b1},  // R1 open
        {1'b1, 1'b1, 2'd1, 8'h33, 8'h80, 1'b1},  // R1 short-high
        {1'b1, 1'b1, 2'd2, 8'h2A, 8'h80, 1'b1},  // R1 pair-short
        {1'b1, 1'b1, 2'd3, 8'h3C, 8'h3C, 1'b1},  // R2 negative-to-ground, R7
        {1'b0, 1'b1, 2'd0, 8'h50, 8'h00, 1'b0},  // R3
        {1'b0, 1'b1, 2'd3, 8'h50, 8'h00, 1'b0},  // R3
        {1'b0, 1'b0, 2'd0, 8'h61, 8'h61, 1'b0},  // R4 disabled, no fault
        {1'b1, 1'b0, 2'd0, 8'h80, 8'h80, 1'b0},  // R6 measured sentinel
        {1'b0, 1'b0, 2'd0, 8'h80, 8'h80, 1'b0}   // R6 disabled, measured
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic convert();
        @(negedge clk) conv_done = 1'b1;
        @(negedge clk) conv_done = 1'b0;
    endtask

    task automatic clear_all();
        @(negedge clk) begin fault_clr = '1; err_clr = '1; end
        @(negedge clk) begin fault_clr = '0; err_clr = '0; end
    endtask

    initial begin
        #(5.0 * 100000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired, run hung actual=0 expected=1");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        chk("R10 reading", 32'(temp_reading), 32'h0);
        chk("R10 status", 32'({fault_sts, diode_err}), 32'h0);
        chk("R10 fan", 32'(fan_full), 32'h0);
        rst_n = 1'b1;

        // table walk on channel 0; channel 1 enabled, healthy, mask 0
        chan_en[1] = 1'b1;
        raw_temp[15:8] = 8'h20;
        zone_mask = {3'b000, 3'b101};
        for (int i = 0; i < NV; i++) begin
            @(negedge clk) begin
                chan_en[0]        = VEC[i][20];
                fault_det[0]      = VEC[i][19];
                fault_kind[1:0]   = VEC[i][18:17];
                raw_temp[7:0]     = VEC[i][16:9];
            end
            convert();
            chk($sformatf("R1-table reading v%0d", i), 32'(temp_reading[7:0]), 32'(VEC[i][8:1]));
            chk($sformatf("R7 fault bit v%0d", i), 32'(fault_sts[0]), 32'(VEC[i][0]));
            chk($sformatf("R6 error v%0d", i), 32'(diode_err[0]), 32'(VEC[i][8:1] == 8'h80));
            chk($sformatf("R8 fan v%0d", i), 32'(fan_full), (VEC[i][8:1] == 8'h80) ? 32'h5 : 32'h0);
            clear_all();
            chk($sformatf("R9 cleared v%0d", i), 32'({fault_sts[0], diode_err[0]}), 32'h0);
        end

        // R5: inputs move without a strobe, reading holds
        @(negedge clk) begin
            chan_en[0] = 1'b1; fault_det[0] = 1'b0; raw_temp[7:0] = 8'h41;
        end
        convert();
        @(negedge clk) begin fault_det[0] = 1'b1; raw_temp[7:0] = 8'h77; end
        repeat (4) @(negedge clk);
        chk("R5 hold", 32'(temp_reading[7:0]), 32'h41);
        chk("R5 no fault bit", 32'(fault_sts[0]), 32'h0);

        // R8: two channels, union of masks, then drop on recovery
        @(negedge clk) begin
            zone_mask = {3'b010, 3'b101};
            fault_det = 2'b11; fault_kind = 4'b0000;
        end
        convert();
        chk("R8 union", 32'(fan_full), 32'h7);
        @(negedge clk) begin fault_det = 2'b10; raw_temp[7:0] = 8'h30; end
        convert();
        chk("R8 drop ch0", 32'(fan_full), 32'h2);
        // R9: bits stay set though reading recovered
        chk("R9 sticky fault", 32'(fault_sts), 32'h3);
        chk("R9 sticky err", 32'(diode_err), 32'h3);
        clear_all();

        // R9: set wins over a clear on the same edge
        @(negedge clk) begin
            fault_det = 2'b01; conv_done = 1'b1; fault_clr = 2'b01; err_clr = 2'b01;
        end
        @(negedge clk) begin conv_done = 1'b0; fault_clr = '0; err_clr = '0; end
        chk("R9 set wins fault", 32'(fault_sts[0]), 32'h1);
        chk("R9 set wins err", 32'(diode_err[0]), 32'h1);

        // R7: negative-to-ground sets fault bit only, no error, no fan
        clear_all();
        @(negedge clk) begin fault_det = 2'b00; raw_temp[7:0] = 8'h25; end
        convert();
        @(negedge clk) begin fault_det = 2'b01; fault_kind[1:0] = 2'd3; raw_temp[7:0] = 8'h55; end
        convert();
        chk("R2 raw kept", 32'(temp_reading[7:0]), 32'h55);
        chk("R7 fault set", 32'(fault_sts[0]), 32'h1);
        chk("R7 no error", 32'(diode_err[0]), 32'h0);
        chk("R7 no fan", 32'(fan_full), 32'h0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule